// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block raises a level interrupt toward the CPU after a programmable number of video scanlines. Software loads an 8-bit reload value, arms a reload, and enables the interrupt through a small set of write-only registers. Each scanline is signalled by a single-cycle pulse from outside logic. On each pulse the counter is either refilled from the reload value or decremented by one.

The counter only advances while the surrounding cartridge logic is in its indexed-banking mode, which is shown by a mode-active input. When the counter is zero after an update and the interrupt is enabled, the interrupt line goes high. It stays high until software acknowledges it. A reload value of zero therefore requests an interrupt on every scanline. The block does no scanline detection and no bank mapping of its own.

Top module: `scl_irq_top`

## Requirements
- R1: After reset the interrupt output is low, and the reload value, counter, enable flag and pending-reload flag are all zero. A first enabled scanline pulse after reset therefore loads zero and raises the interrupt.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 (for example 0xC000 or 0xDFFE) stores the data byte as the reload value. It has no effect on the interrupt output.
- R3: A write decoded as 0xC001 sets the pending-reload flag and leaves the counter unchanged. The next counted pulse loads the reload value and clears the flag.
- R4: A write decoded as 0xE000 clears the enable flag and drops the interrupt output on the following cycle.
- R5: A write decoded as 0xE001 sets the enable flag.
- R6: On a counted pulse, if the counter is zero or a reload is pending, the counter takes the reload value. Otherwise it decrements by one.
- R7: If the counter is zero after a counted pulse and the enable flag is set, the interrupt output goes high. It stays high, across further pulses and idle cycles, until an acknowledge write (R4).
- R8: Scanline pulses while mode_active is low change no state.
- R9: With a reload value of zero, every counted pulse raises the interrupt.
- R10: When a register write and a pulse arrive in the same cycle, the write takes effect first and the pulse uses the updated values.
- R11: A counter that reaches zero while the interrupt is disabled raises nothing, and enabling afterwards does not raise the interrupt until the next counted pulse that leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe, one cycle per write |
| cpu_addr | input | 16 | Write address |
| cpu_data | input | 8 | Write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| mode_active | input | 1 | High while the indexed-banking mode is selected |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check these counter and flag rules:
- the counter holds steady when no pulse is counted;
- it decrements by exactly one when no reload applies;
- it refills from the reload value when a reload is pending;
- the interrupt is sticky until acknowledged, and the acknowledge clears both the interrupt and the enable flag.

Some behaviour shows only at the interrupt pin over a sequence of writes and pulses, so only the bench scenarios can show it. This covers the exact scanline on which the interrupt fires for reload values 0, 1 and 3. It also covers the delay that pulses ignored while the mode is inactive add to that firing, the ordering of a write and a pulse in the same cycle, and the silent expiry of a disabled counter.

// File: rtl/scl_irq_pkg.sv
package scl_irq_pkg;

    // Decoded register command, at most one field set per write
    typedef struct packed {
        logic set_latch;
        logic arm_reload;
        logic irq_off;
        logic irq_on;
    } scl_cmd_t;

endpackage

// File: rtl/scl_irq_decode.sv
module scl_irq_decode
    import scl_irq_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] DEC_MASK   = 16'hE001,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hC000,
    parameter logic [ADDR_W-1:0] ARM_ADDR   = 16'hC001,
    parameter logic [ADDR_W-1:0] OFF_ADDR   = 16'hE000,
    parameter logic [ADDR_W-1:0] ON_ADDR    = 16'hE001
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output scl_cmd_t          cmd_o
);

    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked           = addr_i & DEC_MASK;
        cmd_o            = '0;
        cmd_o.set_latch  = wr_i && (masked == LATCH_ADDR);
        cmd_o.arm_reload = wr_i && (masked == ARM_ADDR);
        cmd_o.irq_off    = wr_i && (masked == OFF_ADDR);
        cmd_o.irq_on     = wr_i && (masked == ON_ADDR);
    end

endmodule

// File: rtl/scl_irq_count.sv
module scl_irq_count
    import scl_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scl_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             line_pulse_i,
    input  logic             mode_active_i,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] latch;
        logic [CNT_W-1:0] cnt;
        logic             reload;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic       step;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        step  = line_pulse_i && mode_active_i;
        // Register writes land before the scanline update (R10)
        if (cmd_i.set_latch)  st_d.latch  = data_i;
        if (cmd_i.arm_reload) st_d.reload = 1'b1;
        if (step) begin
            if ((st_q.cnt == ZERO) || st_d.reload) begin
                st_d.cnt    = st_d.latch;
                st_d.reload = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            hit_o = (st_d.cnt == ZERO);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pulse_i && mode_active_i) |=> $stable(st_q.cnt));

    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse_i && mode_active_i && st_q.cnt != ZERO && !st_q.reload && !cmd_i.arm_reload)
        |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse_i && mode_active_i && st_q.reload && !cmd_i.set_latch)
        |=> (st_q.cnt == $past(st_q.latch)) && !st_q.reload);

    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.arm_reload && !(line_pulse_i && mode_active_i))
        |=> st_q.reload && $stable(st_q.cnt));

endmodule

// File: rtl/scl_irq_flag.sv
module scl_irq_flag
    import scl_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  scl_cmd_t cmd_i,
    input  logic     hit_i,
    output logic     irq_o
);

    typedef struct packed {
        logic en;
        logic irq;
    } flag_state_t;

    flag_state_t fl_q, fl_d;

    always_comb begin
        fl_d = fl_q;
        if (cmd_i.irq_on) fl_d.en = 1'b1;
        if (cmd_i.irq_off) begin
            fl_d.en  = 1'b0;
            fl_d.irq = 1'b0;
        end
        if (hit_i && fl_d.en) fl_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign irq_o = fl_q.irq;

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.irq && !cmd_i.irq_off) |=> fl_q.irq);

    p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.irq_off |=> !fl_q.irq && !fl_q.en);

    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.irq_on && !cmd_i.irq_off) |=> fl_q.en);

    p_rise_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.irq) |-> $past(hit_i));

endmodule

// File: rtl/scl_irq_top.sv
module scl_irq_top
    import scl_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              line_pulse,
    input  logic              mode_active,
    output logic              irq
);

    localparam int CNT_W = DATA_W;

    scl_cmd_t cmd;
    logic     hit;

    scl_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_i   (cpu_wr),
        .addr_i (cpu_addr),
        .cmd_o  (cmd)
    );

    scl_irq_count #(.CNT_W(CNT_W)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .data_i        (cpu_data),
        .line_pulse_i  (line_pulse),
        .mode_active_i (mode_active),
        .hit_o         (hit)
    );

    scl_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd),
        .hit_i (hit),
        .irq_o (irq)
    );

    p_onehot_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

endmodule

// File: tb/test_scl_irq_top.sv
module test_scl_irq_top;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        pulse;
        logic        mode;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 44;
    // wr, addr, data, pulse, mode, expected irq, requirement number
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'hC000, 8'd3, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 reload value 3
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 enable
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 zero -> load 3
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 2
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 1
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 0 -> fire
        '{1'b0, 16'h0000, 8'd0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 held idle
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 held over reload
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 ack
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 ignored
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 ignored
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd8},  // 2
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd8},  // 1
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd8},  // 0 -> fire
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // load 3
        '{1'b1, 16'hC000, 8'd1, 1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'hC001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 arm, count stays 3
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 load 1
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd3},  // 0 -> fire
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // load 1
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd7},
        '{1'b1, 16'hDFFE, 8'd0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 alias, irq untouched
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 every line
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 again
        '{1'b1, 16'hE000, 8'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd11}, // R11 silent expiry
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd11}, // R11 enable alone
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd11},
        '{1'b1, 16'hE000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 ack before pulse
        '{1'b1, 16'hC000, 8'd2, 1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 16'hE001, 8'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd6},  // load 2
        '{1'b1, 16'hC001, 8'd0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 arm+pulse reloads 2
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b0, 4'd10}, // 1, not 0
        '{1'b0, 16'h0000, 8'd0, 1'b1, 1'b1, 1'b1, 4'd10}  // 0 -> fire
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        line_pulse = 1'b0;
    logic        mode_active = 1'b0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scl_irq_top i_scl_irq_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .line_pulse  (line_pulse),
        .mode_active (mode_active),
        .irq         (irq)
    );

    task automatic check(input logic exp, input int req, input int idx);
        n_run++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL R%0d step %0d: irq=%0b expected %0b", req, idx, irq, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [15:0] a, input logic [7:0] d,
                         input logic p, input logic m);
        cpu_wr = w; cpu_addr = a; cpu_data = d; line_pulse = p; mode_active = m;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 1, -1);                       // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].pulse, VECS[i].mode);
            @(negedge clk);
            check(VECS[i].exp, int'(VECS[i].req), i);
        end
        drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        // R1: reset while the interrupt is high clears it
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, 1, 100);
        rst_n = 1'b1;
        // R1: reload value and counter reset to zero, so first pulse fires
        drive(1'b1, 16'hE001, 8'h0, 1'b0, 1'b1);
        @(negedge clk);
        check(1'b0, 1, 101);
        drive(1'b0, 16'h0, 8'h0, 1'b1, 1'b1);
        @(negedge clk);
        check(1'b1, 1, 102);
        drive(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        @(negedge clk);
        check(1'b1, 7, 103);                      // R7 hold
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule